// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial bit clock of an SPI controller from a faster reference clock. The reference is divided by a ratio chosen in one of three ways. The first is a two-stage prescaler: a linear pre-divider times a power-of-two post-divider. The second is a compact rate code that gives four times a power of two. The third is an index into a fixed list of divisors that includes non-power-of-two values such as 3, 6 and 12. Software works out the field values for a target bit rate. The block only turns them into a clean clock.

The block produces the divided clock with a selectable idle level and a strobe that marks each coming clock transition. A serializer can use that strobe to shift or sample. Start and stop are controlled by a run input. Divider changes made while the clock runs are taken up only at the end of a full period, so the output never carries a shortened pulse. A configuration that cannot be decoded keeps the clock from starting, or ends it at the next period end, and raises an error flag.

Top module: `spi_clk_div`

## Requirements
- R1: With mode_i = 0 the ratio is (pre+1)·2^post, with pre in cfg_i[15:12] and post in cfg_i[11:8]. A resulting ratio of 1 is invalid.
- R2: With mode_i = 1 the code n in cfg_i[2:0] gives a ratio of 4·2^n for n = 0..6. Code 7 is invalid, and cfg_i[7:3] are ignored.
- R3: With mode_i = 2 the index in cfg_i[7:0] selects, for indices 2 to 18, the ratios 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024 in that order. Index 0 and indices above 18 are invalid.
- R4: Table index 1 gives a ratio of 3 when odd3_en_i is high and is invalid when it is low.
- R5: Each sclk_o period lasts exactly the ratio in reference cycles. The high phase lasts floor(ratio/2) cycles and the low phase lasts the rest, so for odd ratios the high phase is the shorter one.
- R6: While stopped, sclk_o follows cpol_i one cycle later. When run_i is sampled high with a valid ratio, sclk_o first holds the idle level for its complete phase length, counted from that edge, before the first transition.
- R7: When run_i is low during the idle-level phase, the clock stops at once with no transition. When it is low during the active phase, that phase completes and the clock stops on its return to idle. Either way sclk_o ends at the idle level.
- R8: Changes to mode_i and cfg_i while running take effect only at the next return to the idle level (end of a period). The phase in progress is never altered.
- R9: tick_o is high in exactly those running cycles that precede an sclk_o transition.
- R10: mode_i = 3 is invalid. err_o goes high one cycle after run_i is high together with an invalid configuration. An invalid configuration never starts the clock, and a running clock meeting one stops at the next period end.
- R11: During and just after reset, sclk_o, tick_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Clock run request |
| mode_i | input | 2 | Division scheme: 0 two-stage, 1 rate code, 2 table, 3 invalid |
| cfg_i | input | 16 | Divider fields: pre [15:12], post [11:8], code/index [7:0] |
| odd3_en_i | input | 1 | Permits the divide-by-3 table entry |
| cpol_i | input | 1 | Idle level of sclk_o |
| sclk_o | output | 1 | Divided serial clock |
| tick_o | output | 1 | High in the cycle before each sclk_o transition |
| err_o | output | 1 | Invalid configuration requested while run_i is high |

## Verification
The assertions assume cpol_i is held steady while the clock runs. They also assume that mode_i and cfg_i only change between clock edges, since the decoded ratio is sampled at period ends. The stimulus changes polarity only while stopped, with two settle cycles before each run. It alters the divider fields only at a known point inside the active phase, which is where the boundary rule of R8 is exercised. Phase lengths are then measured purely from sclk_o transitions against ratios computed from an independent divisor list.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic [1:0] {
    DIV_TWO_STAGE = 2'd0,
    DIV_RATE      = 2'd1,
    DIV_TABLE     = 2'd2,
    DIV_NONE      = 2'd3
  } div_mode_e;

  localparam int unsigned TBL_LAST  = 18;
  localparam int unsigned RATE_LAST = 6;
  localparam int unsigned TBL_MIN_W = 11;
endpackage

// File: rtl/spi_div_ratio.sv
module spi_div_ratio
  import spi_div_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int POST_W  = 4,
  parameter int SEL_W   = 8,
  parameter int CODE_W  = 3,
  parameter int RATIO_W = 20
) (
  input  logic [1:0]                     mode_i,
  input  logic [PRE_W+POST_W+SEL_W-1:0]  cfg_i,
  input  logic                           odd3_en_i,
  output logic [RATIO_W-1:0]             ratio_o,
  output logic                           ok_o
);
  localparam int CFG_W = PRE_W + POST_W + SEL_W;

  logic [PRE_W-1:0]   pre;
  logic [POST_W-1:0]  post;
  logic [SEL_W-1:0]   sel;
  logic [CODE_W-1:0]  code;
  logic [SEL_W-1:0]   k;
  logic [RATIO_W-1:0] two_r, rate_r, tbl_r;

  assign pre  = cfg_i[CFG_W-1 -: PRE_W];
  assign post = cfg_i[SEL_W +: POST_W];
  assign sel  = cfg_i[SEL_W-1:0];
  assign code = sel[CODE_W-1:0];

  always_comb begin
    two_r  = (RATIO_W'(pre) + RATIO_W'(1)) << post;
    rate_r = RATIO_W'(4) << code;
    // table entries from index 2 alternate 4*2^j and 6*2^j
    k      = sel - SEL_W'(2);
    tbl_r  = (k[0] ? RATIO_W'(6) : RATIO_W'(4)) << k[SEL_W-1:1];
    ratio_o = '0;
    ok_o    = 1'b0;
    case (div_mode_e'(mode_i))
      DIV_TWO_STAGE: begin
        ratio_o = two_r;
        ok_o    = (two_r >= RATIO_W'(2));
      end
      DIV_RATE: begin
        ratio_o = rate_r;
        ok_o    = (code <= CODE_W'(RATE_LAST));
      end
      DIV_TABLE: begin
        if (sel == SEL_W'(1)) begin
          ratio_o = RATIO_W'(3);
          ok_o    = odd3_en_i;
        end else begin
          ratio_o = tbl_r;
          ok_o    = (sel >= SEL_W'(2)) && (sel <= SEL_W'(TBL_LAST));
        end
      end
      default: begin
        ratio_o = '0;
        ok_o    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase #(
  parameter int RATIO_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               pol_i,
  input  logic               ok_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sclk_o,
  output logic               tick_o
);
  logic               busy_q, sclk_q, pol_q;
  logic [RATIO_W-1:0] ratio_q, cnt_q, half_len;
  logic               last, stop_now, bound;

  always_comb begin
    // high phase takes the floor half
    half_len = sclk_q ? (ratio_q >> 1) : (ratio_q - (ratio_q >> 1));
    last     = busy_q && (cnt_q == half_len - RATIO_W'(1));
    stop_now = busy_q && !run_i && (sclk_q == pol_q);
    bound    = last && !stop_now && (sclk_q != pol_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      pol_q   <= 1'b0;
      ratio_q <= '0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      sclk_q <= pol_i;
      pol_q  <= pol_i;
      cnt_q  <= '0;
      if (run_i && ok_i) begin
        busy_q  <= 1'b1;
        ratio_q <= ratio_i;
      end
    end else if (stop_now) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (last) begin
      sclk_q <= ~sclk_q;
      cnt_q  <= '0;
      if (bound) begin
        if (run_i && ok_i) ratio_q <= ratio_i;
        else               busy_q  <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = last && !stop_now;

  // R9
  tick_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (sclk_o != $past(sclk_o)));
  // R9
  toggle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_q) && (sclk_o != $past(sclk_o))) |-> $past(tick_o));
  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < half_len));
  // R8
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(bound)) |-> (ratio_q == $past(ratio_q)));
  // R10
  ratio_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (ratio_q >= RATIO_W'(2)));
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_div_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4,
  parameter int SEL_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic [1:0]                    mode_i,
  input  logic [PRE_W+POST_W+SEL_W-1:0] cfg_i,
  input  logic                          odd3_en_i,
  input  logic                          cpol_i,
  output logic                          sclk_o,
  output logic                          tick_o,
  output logic                          err_o
);
  localparam int TWO_W   = PRE_W + (1 << POST_W);
  localparam int RATIO_W = (TWO_W > int'(TBL_MIN_W)) ? TWO_W : int'(TBL_MIN_W);

  logic [RATIO_W-1:0] ratio;
  logic               ratio_ok;
  logic               err_q;

  spi_div_ratio #(
    .PRE_W(PRE_W), .POST_W(POST_W), .SEL_W(SEL_W), .CODE_W(CODE_W), .RATIO_W(RATIO_W)
  ) u_ratio (
    .mode_i   (mode_i),
    .cfg_i    (cfg_i),
    .odd3_en_i(odd3_en_i),
    .ratio_o  (ratio),
    .ok_o     (ratio_ok)
  );

  spi_div_phase #(.RATIO_W(RATIO_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .pol_i  (cpol_i),
    .ok_i   (ratio_ok),
    .ratio_i(ratio),
    .sclk_o (sclk_o),
    .tick_o (tick_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= run_i && !ratio_ok;
  end

  assign err_o = err_q;

  // R10
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(tick_o) && $past(sclk_o) == $past(cpol_i) && !tick_o
     && $past(err_o)) |-> (sclk_o == $past(sclk_o)));
endmodule

// File: tb/spi_clk_div_test.sv
`timescale 1ns/1ps
module spi_clk_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] cfg = 16'h0;
  logic        odd3 = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk_o, tick_o, err_o;

  spi_clk_div uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .mode_i(mode), .cfg_i(cfg),
    .odd3_en_i(odd3), .cpol_i(cpol), .sclk_o(sclk_o), .tick_o(tick_o), .err_o(err_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct { int act; int idl; string tag; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ref_stamp = 0, act_start = 0;
  bit mon_en = 0, pol_cur = 0, sclk_prev = 0, tick_prev = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [1:0] m, input logic [15:0] c, input logic o);
    int tbl[19] = '{0, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 768, 1024};
    int r;
    case (m)
      2'd0: begin r = (int'(c[15:12]) + 1) << c[11:8]; if (r < 2) r = 0; end
      2'd1: r = (c[2:0] == 3'd7) ? 0 : (4 << c[2:0]);
      2'd2: begin
        if (c[7:0] == 8'd0 || c[7:0] > 8'd18) r = 0;
        else if (c[7:0] == 8'd1 && !o) r = 0;
        else r = tbl[c[7:0]];
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic push(input int r, input bit p, input string tag);
    item_t it;
    it.act = p ? r - r / 2 : r / 2;
    it.idl = p ? r / 2 : r - r / 2;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: measures phase lengths from sclk transitions
  always @(negedge clk_i) begin
    if (rst_ni && mon_en) begin
      if (sclk_o != sclk_prev) begin
        check(tick_prev, "R9 tick before transition", tick_prev, 1);
        if (exp_q.size() == 0) begin
          check(0, "R7/R10 unexpected transition", sclk_o, sclk_prev);
        end else if (sclk_o != pol_cur) begin
          check(cyc - ref_stamp == exp_q[0].idl, {exp_q[0].tag, " idle phase"},
                cyc - ref_stamp, exp_q[0].idl);
          act_start = cyc;
        end else begin
          check(cyc - act_start == exp_q[0].act, {exp_q[0].tag, " active phase"},
                cyc - act_start, exp_q[0].act);
          void'(exp_q.pop_front());
          ref_stamp = cyc;
        end
      end else if (tick_prev) begin
        check(0, "R9 tick without transition", tick_prev, 0);
      end
    end
    sclk_prev = sclk_o;
    tick_prev = tick_o;
  end

  task automatic setup(input logic [1:0] m, input logic [15:0] c, input logic o, input logic p);
    @(negedge clk_i);
    mon_en = 0; mode = m; cfg = c; odd3 = o; cpol = p; pol_cur = p;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_case(input logic [1:0] m, input logic [15:0] c, input logic o, input logic p,
                          input int np, input bit chg, input logic [1:0] m2, input logic [15:0] c2,
                          input string tag);
    int r1, r2, n;
    r1 = exp_ratio(m, c, o);
    r2 = chg ? exp_ratio(m2, c2, o) : r1;
    n  = (r2 == 0) ? 1 : np;
    setup(m, c, o, p);
    mon_en = 1; ref_stamp = cyc + 1; run = 1;
    for (int i = 0; i < n; i++) push((i == 0) ? r1 : r2, p, tag);
    if (chg) begin
      do @(negedge clk_i); while (sclk_o == p);
      mode = m2; cfg = c2;
    end
    if (r2 == 0) begin
      while (exp_q.size() != 0) @(negedge clk_i);
      repeat (2) @(negedge clk_i);
      check(err_o == 1'b1, "R10 error after invalid update", err_o, 1);
    end else begin
      while (!(exp_q.size() == 1 && sclk_o != p)) @(negedge clk_i);
      run = 0;
      while (exp_q.size() != 0) @(negedge clk_i);
    end
    run = 0;
    repeat (4) @(negedge clk_i);
    check(sclk_o == p, {tag, " R7 rests at idle"}, sclk_o, p);
  endtask

  task automatic err_case(input logic [1:0] m, input logic [15:0] c, input logic o, input logic p,
                          input string tag);
    setup(m, c, o, p);
    mon_en = 1; run = 1;
    repeat (2) @(negedge clk_i);
    check(err_o == 1'b1, {tag, " R10 err flag"}, err_o, 1);
    repeat (10) @(negedge clk_i);
    check(sclk_o == p, {tag, " R10 held idle"}, sclk_o, p);
    run = 0;
    repeat (2) @(negedge clk_i);
    check(err_o == 1'b0, {tag, " R10 err clears"}, err_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(sclk_o == 0 && tick_o == 0 && err_o == 0, "R11 in reset",
          {sclk_o, tick_o, err_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(sclk_o == 0 && tick_o == 0 && err_o == 0, "R11 after reset",
          {sclk_o, tick_o, err_o}, 0);

    // R1 R5 R6: two-stage prescaler
    run_case(2'd0, 16'h2300, 0, 0, 2, 0, 0, 0, "R1 pre2 post3");
    run_case(2'd0, 16'h1000, 0, 1, 3, 0, 0, 0, "R1 ratio2 R6 idle high");
    run_case(2'd0, 16'hF200, 0, 0, 1, 0, 0, 0, "R1 pre15 post2");
    // R2: rate code, upper bits ignored
    run_case(2'd1, 16'h00F8, 0, 0, 2, 0, 0, 0, "R2 code0");
    run_case(2'd1, 16'h0006, 0, 1, 1, 0, 0, 0, "R2 code6");
    // R3: table
    run_case(2'd2, 16'h0002, 0, 0, 2, 0, 0, 0, "R3 idx2");
    run_case(2'd2, 16'h0007, 0, 1, 2, 0, 0, 0, "R3 idx7");
    run_case(2'd2, 16'h000D, 0, 1, 1, 0, 0, 0, "R3 idx13");
    run_case(2'd2, 16'h0012, 0, 0, 1, 0, 0, 0, "R3 idx18");
    // R4 R5: divide by 3, odd split
    run_case(2'd2, 16'h0001, 1, 0, 3, 0, 0, 0, "R4 R5 div3 low idle");
    run_case(2'd2, 16'h0001, 1, 1, 2, 0, 0, 0, "R4 R5 div3 high idle");
    // R8: change while running lands at period end
    run_case(2'd1, 16'h0000, 0, 0, 3, 1, 2'd1, 16'h0001, "R8 4 to 8");
    run_case(2'd2, 16'h0004, 0, 1, 3, 1, 2'd0, 16'h2000, "R8 8 to 3x");
    // R10: invalid config reached while running
    run_case(2'd1, 16'h0000, 0, 0, 2, 1, 2'd3, 16'h0000, "R10 stop on invalid");
    // R10 R1 R2 R3 R4: invalid configurations
    err_case(2'd3, 16'h0000, 0, 0, "R10 mode3");
    err_case(2'd0, 16'h0000, 0, 1, "R1 ratio1");
    err_case(2'd1, 16'h0007, 0, 0, "R2 code7");
    err_case(2'd2, 16'h0000, 0, 0, "R3 idx0");
    err_case(2'd2, 16'h0013, 0, 1, "R3 idx19");
    err_case(2'd2, 16'h0001, 0, 0, "R4 div3 disabled");
    // R7: stop inside the idle-level phase, no transition at all
    setup(2'd1, 16'h0001, 0, 0);
    mon_en = 1; run = 1;
    repeat (2) @(negedge clk_i);
    run = 0;
    repeat (12) @(negedge clk_i);
    check(sclk_o == 1'b0, "R7 early stop stays idle", sclk_o, 0);
    // R6: idle level follows cpol_i while stopped
    mon_en = 0; cpol = 1;
    repeat (2) @(negedge clk_i);
    check(sclk_o == 1'b1, "R6 idle follows polarity", sclk_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule